// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-side programming port of a four-channel DMA engine. A processor reaches it through an 8-bit data bus, a 4-bit port number and separate read and write strobes. Behind those eight-bit ports sit each channel's 16-bit base and current address, base and current count, a mode field and a mask bit. It also holds a command byte, a per-channel software request vector and a status byte. The transfer sequencers read the programmed configuration from flat output vectors.

A 16-bit value crosses the bus as two accesses to the same port. One byte-pointer flip-flop, shared by all channels, selects the low or the high byte. Software first writes the pointer-clear port, then moves the low byte followed by the high byte. Control ports that act on a single channel take the channel number from data bits 1:0.

Top module: `dmac_regport`

## Requirements
- R1: After reset, every mask bit is 1, the command byte, the request vector and all mode fields are 0, the byte pointer selects the low byte, and all address and count registers read as 0.
- R2: Port 2n writes channel n's address and port 2n+1 writes its count. Each write loads the selected byte of the base and the current register together: the low byte when the pointer is low, the high byte when it is high.
- R3: A read strobe on port 2n or 2n+1 returns the byte of channel n's current address or current count that the pointer selects. The byte appears on the read data output one cycle after the strobe and holds until the next read strobe.
- R4: Every read or write of a port 0x0 to 0x7 toggles the shared byte pointer, whichever channel that port belongs to.
- R5: A write to port 0xC returns the pointer to the low-byte state, whatever data is written.
- R6: A write to port 0xA sets mask bit wdata[1:0] to wdata[2], where 1 disables the channel. The other mask bits are unchanged.
- R7: A write to port 0xB stores wdata[7:2] as the mode field of channel wdata[1:0], and the other channels keep their mode fields. Examples: 0x40|ch gives field 0x10, 0x48|ch gives 0x12 and 0xC0|ch gives 0x30. Field ch occupies mode_o bits [6*ch+5 : 6*ch].
- R8: A write to port 0xE clears all four mask bits. A write to port 0xF loads the mask bits from wdata[3:0].
- R9: A write to port 0x9 sets request bit wdata[1:0] to wdata[2].
- R10: A status read (read strobe on port 0x8) returns the request vector in bits 7:4 and the latched terminal-count flags in bits 3:0. A pulse on tc_i[n] latches flag n. A status read clears the flags that are not pulsed in the same cycle.
- R11: A write to port 0x8 loads the command byte onto cmd_o.
- R12: A write to port 0xD (master clear) sets all mask bits, clears the command byte, the request vector and the terminal-count flags, and returns the pointer to the low byte. Address, count and mode registers keep their values.
- R13: Reads of ports 0x9 to 0xF return 0x00 and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Port number |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| tc_i | input | 4 | Terminal-count pulses from the sequencers |
| rdata_o | output | 8 | Read data, registered |
| base_addr_o | output | 64 | Base address of channel n in bits [16n+15:16n] |
| base_cnt_o | output | 64 | Base count of channel n in bits [16n+15:16n] |
| mode_o | output | 24 | Mode field of channel n in bits [6n+5:6n] |
| mask_o | output | 4 | Mask bit per channel, 1 = disabled |
| req_o | output | 4 | Software request bit per channel |
| cmd_o | output | 8 | Command byte |

## Verification
All register outputs (masks, modes, request, command and base values) change on the clock edge that samples the write strobe. The bench drives each strobe for one cycle starting at a falling edge and compares these outputs at the next falling edge, half a cycle after that edge. Read data is also due on the edge that samples the read strobe. The driver queues the expected byte when it issues the strobe, and a monitor pops and compares it on the falling edge that follows a cycle in which the read strobe was high. The byte pointer cannot be observed directly, so the bench infers its state from which byte a later read returns or which byte a later write lands in.

// File: rtl/dmac_regport_pkg.sv
package dmac_regport_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NUM_CH = 4;
    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int MODE_W = BYTE_W - SEL_W;
    localparam int PORT_W = 4;

    typedef enum logic [PORT_W-1:0] {
        PORT_CMD_STAT  = 4'h8,
        PORT_REQ       = 4'h9,
        PORT_MASK_ONE  = 4'hA,
        PORT_MODE      = 4'hB,
        PORT_PTR_CLR   = 4'hC,
        PORT_MCLR      = 4'hD,
        PORT_MASK_NONE = 4'hE,
        PORT_MASK_ALL  = 4'hF
    } ctl_port_e;

    typedef struct packed {
        logic [WORD_W-1:0] base_addr;
        logic [WORD_W-1:0] cur_addr;
        logic [WORD_W-1:0] base_cnt;
        logic [WORD_W-1:0] cur_cnt;
    } chan_regs_t;
endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_i,
    input  logic clr_i,
    output logic hi_o
);
    logic ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i)
            ptr_d = 1'b0;
        else if (acc_i)
            ptr_d = ~ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= 1'b0;
        else        ptr_q <= ptr_d;
    end

    assign hi_o = ptr_q;

    assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hi_o)
        else $error("pointer not cleared");

    assert_ptr_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !clr_i) |=> (hi_o != $past(hi_o)))
        else $error("pointer did not toggle");
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_i,
    input  logic              wr_cnt_i,
    input  logic              hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output chan_regs_t        regs_o
);
    chan_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_addr_i) begin
            if (hi_i) begin
                regs_d.base_addr[WORD_W-1:BYTE_W] = wdata_i;
                regs_d.cur_addr[WORD_W-1:BYTE_W]  = wdata_i;
            end else begin
                regs_d.base_addr[BYTE_W-1:0] = wdata_i;
                regs_d.cur_addr[BYTE_W-1:0]  = wdata_i;
            end
        end
        if (wr_cnt_i) begin
            if (hi_i) begin
                regs_d.base_cnt[WORD_W-1:BYTE_W] = wdata_i;
                regs_d.cur_cnt[WORD_W-1:BYTE_W]  = wdata_i;
            end else begin
                regs_d.base_cnt[BYTE_W-1:0] = wdata_i;
                regs_d.cur_cnt[BYTE_W-1:0]  = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    assert_addr_low_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr_i && !hi_i) |=> (regs_o.cur_addr[BYTE_W-1:0] == $past(wdata_i)))
        else $error("address low byte not loaded");

    assert_cnt_high_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_i && hi_i) |=> (regs_o.base_cnt[WORD_W-1:BYTE_W] == $past(wdata_i)))
        else $error("count high byte not loaded");
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_regport_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  logic [PORT_W-1:0]        addr_i,
    input  logic [BYTE_W-1:0]        wdata_i,
    input  logic [NUM_CH-1:0]        tc_i,
    output logic [BYTE_W-1:0]        cmd_o,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [NUM_CH-1:0]        req_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [BYTE_W-1:0]        status_o
);
    typedef struct packed {
        logic [BYTE_W-1:0]                  cmd;
        logic [NUM_CH-1:0]                  mask;
        logic [NUM_CH-1:0]                  req;
        logic [NUM_CH-1:0]                  tc;
        logic [NUM_CH-1:0][MODE_W-1:0]      mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [SEL_W-1:0] sel;

    assign sel = wdata_i[SEL_W-1:0];

    always_comb begin
        ctl_d = ctl_q;
        if (rd_i && addr_i == PORT_CMD_STAT)
            ctl_d.tc = tc_i;
        else
            ctl_d.tc = ctl_q.tc | tc_i;
        if (wr_i) begin
            case (ctl_port_e'(addr_i))
                PORT_CMD_STAT:  ctl_d.cmd = wdata_i;
                PORT_REQ:       ctl_d.req[sel] = wdata_i[SEL_W];
                PORT_MASK_ONE:  ctl_d.mask[sel] = wdata_i[SEL_W];
                PORT_MODE:      ctl_d.mode[sel] = wdata_i[BYTE_W-1:SEL_W];
                PORT_MCLR: begin
                    ctl_d.cmd  = '0;
                    ctl_d.req  = '0;
                    ctl_d.tc   = '0;
                    ctl_d.mask = '1;
                end
                PORT_MASK_NONE: ctl_d.mask = '0;
                PORT_MASK_ALL:  ctl_d.mask = wdata_i[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_o    = ctl_q.cmd;
    assign mask_o   = ctl_q.mask;
    assign req_o    = ctl_q.req;
    assign mode_o   = ctl_q.mode;
    assign status_o = {ctl_q.req, ctl_q.tc};

    assert_mclr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == PORT_MCLR) |=> (mask_o == '1 && cmd_o == '0 && req_o == '0))
        else $error("master clear incomplete");

    assert_single_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == PORT_MASK_ONE) |=> (mask_o[$past(sel)] == $past(wdata_i[SEL_W])))
        else $error("single mask write lost");

    assert_mode_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == PORT_MODE) |=> (ctl_q.mode[$past(sel)] == $past(wdata_i[BYTE_W-1:SEL_W])))
        else $error("mode write lost");

    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == PORT_CMD_STAT && tc_i == '0) |=> (status_o[NUM_CH-1:0] == '0))
        else $error("status flags not cleared by read");
endmodule

// File: rtl/dmac_regport.sv
module dmac_regport
    import dmac_regport_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PORT_W-1:0]        addr_i,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  logic [BYTE_W-1:0]        wdata_i,
    input  logic [NUM_CH-1:0]        tc_i,
    output logic [BYTE_W-1:0]        rdata_o,
    output logic [NUM_CH*WORD_W-1:0] base_addr_o,
    output logic [NUM_CH*WORD_W-1:0] base_cnt_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [NUM_CH-1:0]        req_o,
    output logic [BYTE_W-1:0]        cmd_o
);
    localparam int CH_LSB = 1;
    localparam int CH_MSB = CH_LSB + SEL_W - 1;

    logic             chan_port;
    logic [SEL_W-1:0] chan_idx;
    logic             ptr_hi;
    logic             ptr_clr;
    logic [BYTE_W-1:0] status;
    chan_regs_t       regs [NUM_CH];

    assign chan_port = !addr_i[PORT_W-1];
    assign chan_idx  = addr_i[CH_MSB:CH_LSB];
    assign ptr_clr   = wr_i && (addr_i == PORT_PTR_CLR || addr_i == PORT_MCLR);

    dmac_byte_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .acc_i ((wr_i || rd_i) && chan_port),
        .clr_i (ptr_clr),
        .hi_o  (ptr_hi)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic hit;
        assign hit = wr_i && chan_port && (chan_idx == SEL_W'(ch));
        dmac_chan_regs u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr_i (hit && !addr_i[0]),
            .wr_cnt_i  (hit && addr_i[0]),
            .hi_i      (ptr_hi),
            .wdata_i   (wdata_i),
            .regs_o    (regs[ch])
        );
        assign base_addr_o[ch*WORD_W +: WORD_W] = regs[ch].base_addr;
        assign base_cnt_o[ch*WORD_W +: WORD_W]  = regs[ch].base_cnt;
    end

    dmac_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .tc_i     (tc_i),
        .cmd_o    (cmd_o),
        .mask_o   (mask_o),
        .req_o    (req_o),
        .mode_o   (mode_o),
        .status_o (status)
    );

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        rd_d    = rd_q;
        rd_word = addr_i[0] ? regs[chan_idx].cur_cnt : regs[chan_idx].cur_addr;
        if (rd_i) begin
            if (chan_port)
                rd_d.rdata = ptr_hi ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
            else if (addr_i == PORT_CMD_STAT)
                rd_d.rdata = status;
            else
                rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rdata;

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o))
        else $error("read data moved without a read");

    assert_ctl_read_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i > PORT_CMD_STAT) |=> (rdata_o == '0))
        else $error("write-only port read nonzero");
endmodule

// File: tb/test_dmac_regport.sv
`timescale 1ns/1ps
module test_dmac_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [3:0]  tc_i = '0;
    logic [7:0]  rdata_o;
    logic [63:0] base_addr_o;
    logic [63:0] base_cnt_o;
    logic [23:0] mode_o;
    logic [3:0]  mask_o;
    logic [3:0]  req_o;
    logic [7:0]  cmd_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    logic  rd_seen = 1'b0;

    always #2 clk = ~clk;

    dmac_regport i_dmac_regport (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
        .wdata_i(wdata_i), .tc_i(tc_i), .rdata_o(rdata_o),
        .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o), .mode_o(mode_o),
        .mask_o(mask_o), .req_o(req_o), .cmd_o(cmd_o)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] port, logic [7:0] data);
        @(negedge clk);
        addr_i = port; wdata_i = data; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(logic [3:0] port, int exp, string tag);
        @(negedge clk);
        addr_i = port; rd_i = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= rd_i;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("monitor queue empty", 1, 0);
            end else begin
                chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", mask_o, 4'hF);
        chk("R1 cmd", cmd_o, 0);
        chk("R1 req", req_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 base_addr", base_addr_o, 0);
        rd(4'h0, 8'h00, "R1 addr0 low read");

        // R2 / R3 load and read back channel 1 address
        wr(4'hC, 8'h5A);
        wr(4'h2, 8'h34);
        wr(4'h2, 8'h12);
        chk("R2 base_addr ch1", base_addr_o[31:16], 16'h1234);
        rd(4'h2, 8'h34, "R3 addr1 low");
        rd(4'h2, 8'h12, "R3 addr1 high");

        // R4 shared pointer across channels
        wr(4'hC, 8'h00);
        wr(4'h1, 8'h11);
        wr(4'h1, 8'h22);
        wr(4'h5, 8'hCD);
        rd(4'h1, 8'h22, "R4 count0 high via shared pointer");
        wr(4'h5, 8'hAB);
        chk("R4 base_cnt ch2", base_cnt_o[47:32], 16'h00AB);

        // R5 pointer clear mid sequence
        wr(4'hC, 8'h00);
        wr(4'h6, 8'h55);
        wr(4'hC, 8'hFF);
        wr(4'h6, 8'h66);
        chk("R5 base_addr ch3", base_addr_o[63:48], 16'h0066);

        // R6 single-channel mask
        wr(4'hA, 8'h01);
        chk("R6 unmask ch1", mask_o, 4'hD);
        wr(4'hA, 8'h02);
        chk("R6 unmask ch2", mask_o, 4'h9);
        wr(4'hA, 8'h05);
        chk("R6 mask ch1", mask_o, 4'hB);

        // R7 mode writes
        wr(4'hB, 8'h4B);
        wr(4'hB, 8'hC0);
        wr(4'hB, 8'h41);
        chk("R7 modes", mode_o, (24'h12 << 18) | (24'h10 << 6) | 24'h30);
        wr(4'hB, 8'h48);
        chk("R7 ch0 rewrite", mode_o, (24'h12 << 18) | (24'h10 << 6) | 24'h12);

        // R8 clear all / write all masks
        wr(4'hE, 8'hFF);
        chk("R8 clear all", mask_o, 4'h0);
        wr(4'hF, 8'h0A);
        chk("R8 write all", mask_o, 4'hA);

        // R9 request register
        wr(4'h9, 8'h06);
        chk("R9 set req2", req_o, 4'h4);
        wr(4'h9, 8'h05);
        chk("R9 set req1", req_o, 4'h6);
        wr(4'h9, 8'h02);
        chk("R9 clear req2", req_o, 4'h2);

        // R10 status with terminal count
        @(negedge clk);
        tc_i = 4'b1000;
        @(negedge clk);
        tc_i = 4'b0000;
        rd(4'h8, 8'h28, "R10 status with tc3");
        rd(4'h8, 8'h20, "R10 status after clear");

        // R11 command
        wr(4'h8, 8'hA5);
        chk("R11 cmd", cmd_o, 8'hA5);

        // R12 master clear
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h77);
        wr(4'hD, 8'h00);
        chk("R12 mask", mask_o, 4'hF);
        chk("R12 cmd", cmd_o, 0);
        chk("R12 req", req_o, 0);
        chk("R12 mode kept", mode_o, (24'h12 << 18) | (24'h10 << 6) | 24'h12);
        rd(4'h0, 8'h77, "R12 pointer low after master clear");
        rd(4'h8, 8'h00, "R12 status cleared");

        // R13 write-only ports read zero, pointer unmoved
        wr(4'hC, 8'h00);
        rd(4'hD, 8'h00, "R13 temp read");
        rd(4'hA, 8'h00, "R13 mask port read");
        rd(4'h9, 8'h00, "R13 req port read");
        rd(4'h2, 8'h34, "R13 pointer still low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule